// File: doc/BRIEF.md
# I2C Status Flag Register

This block keeps the event flags of an I2C controller and decides, cycle by cycle, whether each flag is set, held or cleared. The protocol engine feeds it single-cycle event pulses and a few phase levels: address phase, byte-transfer-finished, next byte is the checksum byte, and first data byte. Software reaches it through register strobes: data register read and write, status register read and write, and control register write.

The block returns the packed status word and the master/slave mode bit. Every flag and the mode bit drop to zero in the cycle after the peripheral enable is seen low, and events are ignored while it stays low. The status flags and the mode bit are plain control and status pins, so the block has no streaming interface and no back-pressure.

Top module: `i2c_evt_flags`

## Requirements
- R1: In the cycle after `en` is sampled low, or after reset, `sr_rdata` and `mode_master` read 0. The stop-sequence arm state and the NACK memory are also cleared, and events sampled while `en` is low have no effect.
- R2: Arbitration-lost is status bit 9 and bus-error is status bit 8. Each is set by its event pulse. Each is cleared by `sr_wr` with a 0 in the matching `wdata` bit, and writing 1 there leaves it unchanged. A set in the same cycle as a clear wins.
- R3: Transmit-empty, status bit 7, is set by `ev_tx_empty` unless `ev_addr_phase` or `ev_pec_next` is high or a NACK is held (see R7).
- R4: Transmit-empty is cleared by `ev_start` or `ev_stop`, and by `dr_wr` unless `ev_btf` or `ev_first_byte` is high. A set in the same cycle wins over any clear.
- R5: Receive-not-empty, status bit 6, is set by `ev_rx_full` unless `ev_addr_phase` or `ev_arb_lost` is high in that cycle.
- R6: Receive-not-empty is cleared by `dr_wr`, and by `dr_rd` unless `ev_btf` is high. A set in the same cycle wins.
- R7: An `ev_nack` pulse is held until the next `ev_start`, and a NACK in the same cycle as a start wins. While it is held, and in its own cycle, neither transmit-empty nor stop-detected can be set.
- R8: Stop-detected, status bit 4, is set by `ev_stop` only while `mode_master` is 0 and no NACK is held.
- R9: Stop-detected clears only in two ways: a `cr_wr` that follows an `sr_rd` made while the flag was already 1, or `en` going low (R1). Any `cr_wr` ends the armed state, and a `cr_wr` made without that read leaves the flag set.
- R10: `mode_master` is set by `ev_become_master` and cleared by `ev_arb_lost`. Arbitration loss wins when both arrive in the same cycle.
- R11: Bit 5 and every status bit other than 9, 8, 7, 6 and 4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Peripheral enable |
| ev_addr_phase | input | 1 | Address phase in progress (level) |
| ev_tx_empty | input | 1 | Data register emptied while transmitting (pulse) |
| ev_rx_full | input | 1 | Received byte placed in data register (pulse) |
| ev_nack | input | 1 | NACK received (pulse) |
| ev_btf | input | 1 | Byte-transfer-finished state (level) |
| ev_pec_next | input | 1 | Next byte to send is the checksum byte (level) |
| ev_first_byte | input | 1 | Data write is the first byte of the transfer (level) |
| ev_arb_lost | input | 1 | Arbitration lost (pulse) |
| ev_bus_err | input | 1 | Misplaced start or stop seen (pulse) |
| ev_start | input | 1 | Start condition on the bus (pulse) |
| ev_stop | input | 1 | Stop condition on the bus (pulse) |
| ev_become_master | input | 1 | Engine has taken the bus as master (pulse) |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| sr_rd | input | 1 | Status register read strobe |
| sr_wr | input | 1 | Status register write strobe |
| cr_wr | input | 1 | Control register write strobe |
| wdata | input | SR_W | Write data for status writes |
| sr_rdata | output | SR_W | Status word |
| mode_master | output | 1 | 1 = master, 0 = slave |

## Verification
The properties take no protocol discipline for granted. Pulses may last several cycles, collide with each other, or arrive while `en` is low, and each property only relates an output change to the inputs sampled at the edge that caused it. The stimulus uses that freedom on purpose. Directed sequences walk each suppression and each clear path, and a long pseudo-random sweep then drives every strobe and event independently. That sweep produces set-versus-clear collisions, disable cycles and out-of-order read/write sequences, and a bench-side model derived from the requirements checks every field each cycle.

// File: rtl/i2c_flag_pkg.sv
`timescale 1ns/1ps
package i2c_flag_pkg;
  localparam int unsigned ARB_BIT  = 9;
  localparam int unsigned BERR_BIT = 8;
  localparam int unsigned TXE_BIT  = 7;
  localparam int unsigned RXNE_BIT = 6;
  localparam int unsigned RSVD_BIT = 5;
  localparam int unsigned STOP_BIT = 4;
  localparam int unsigned N_W0C    = 2;

  typedef struct packed {
    logic arb;
    logic berr;
    logic txe;
    logic rxne;
    logic stopf;
  } flag_vec_t;
endpackage

// File: rtl/i2c_w0c_flag.sv
`timescale 1ns/1ps
// Sticky flag: hardware set, software clear by writing 0, dropped when disabled.
module i2c_w0c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_ev,
  input  logic sw_wr,
  input  logic sw_bit,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 q <= 1'b0;
    else if (!en)               q <= 1'b0;
    else if (set_ev)            q <= 1'b1;
    else if (sw_wr && !sw_bit)  q <= 1'b0;
  end
endmodule

// File: rtl/i2c_data_flags.sv
`timescale 1ns/1ps
// Transmit-empty and receive-not-empty flags with their suppression rules.
module i2c_data_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic addr_phase,
  input  logic tx_empty,
  input  logic rx_full,
  input  logic nack_block,
  input  logic pec_next,
  input  logic first_byte,
  input  logic btf,
  input  logic arb_lost,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic dr_rd,
  input  logic dr_wr,
  output logic txe,
  output logic rxne
);
  logic txe_set, txe_clr, rxne_set, rxne_clr;

  always_comb begin
    txe_set  = tx_empty && !addr_phase && !pec_next && !nack_block;
    txe_clr  = bus_start || bus_stop || (dr_wr && !btf && !first_byte);
    rxne_set = rx_full && !addr_phase && !arb_lost;
    rxne_clr = dr_wr || (dr_rd && !btf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe  <= 1'b0;
      rxne <= 1'b0;
    end else if (!en) begin
      txe  <= 1'b0;
      rxne <= 1'b0;
    end else begin
      if (txe_set)       txe <= 1'b1;
      else if (txe_clr)  txe <= 1'b0;
      if (rxne_set)      rxne <= 1'b1;
      else if (rxne_clr) rxne <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_stop_seq.sv
`timescale 1ns/1ps
// Stop-detected flag, its read-then-write clear sequence, and the NACK memory.
module i2c_stop_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic nack,
  input  logic bus_start,
  input  logic bus_stop,
  input  logic is_master,
  input  logic sr_rd,
  input  logic cr_wr,
  output logic stopf,
  output logic nack_block
);
  logic nack_held, armed;

  assign nack_block = nack_held || nack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nack_held <= 1'b0;
      armed     <= 1'b0;
      stopf     <= 1'b0;
    end else if (!en) begin
      nack_held <= 1'b0;
      armed     <= 1'b0;
      stopf     <= 1'b0;
    end else begin
      if (nack)           nack_held <= 1'b1;
      else if (bus_start) nack_held <= 1'b0;

      if (cr_wr)               armed <= 1'b0;
      else if (sr_rd && stopf) armed <= 1'b1;

      if (bus_stop && !is_master && !nack_block) stopf <= 1'b1;
      else if (cr_wr && armed)                   stopf <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_evt_flags.sv
`timescale 1ns/1ps
module i2c_evt_flags
  import i2c_flag_pkg::*;
#(
  parameter int unsigned SR_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            ev_addr_phase,
  input  logic            ev_tx_empty,
  input  logic            ev_rx_full,
  input  logic            ev_nack,
  input  logic            ev_btf,
  input  logic            ev_pec_next,
  input  logic            ev_first_byte,
  input  logic            ev_arb_lost,
  input  logic            ev_bus_err,
  input  logic            ev_start,
  input  logic            ev_stop,
  input  logic            ev_become_master,
  input  logic            dr_rd,
  input  logic            dr_wr,
  input  logic            sr_rd,
  input  logic            sr_wr,
  input  logic            cr_wr,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] sr_rdata,
  output logic            mode_master
);
  localparam int unsigned W0C_POS [N_W0C] = '{ARB_BIT, BERR_BIT};

  flag_vec_t        flags;
  logic [N_W0C-1:0] w0c_set, w0c_q;
  logic             nack_block;
  logic             unused_wdata;

  assign unused_wdata = ^wdata;
  assign w0c_set      = {ev_bus_err, ev_arb_lost};

  for (genvar i = 0; i < N_W0C; i++) begin : g_w0c
    i2c_w0c_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (en),
      .set_ev (w0c_set[i]),
      .sw_wr  (sr_wr),
      .sw_bit (wdata[W0C_POS[i]]),
      .q      (w0c_q[i])
    );
  end

  i2c_data_flags u_data (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .addr_phase (ev_addr_phase),
    .tx_empty   (ev_tx_empty),
    .rx_full    (ev_rx_full),
    .nack_block (nack_block),
    .pec_next   (ev_pec_next),
    .first_byte (ev_first_byte),
    .btf        (ev_btf),
    .arb_lost   (ev_arb_lost),
    .bus_start  (ev_start),
    .bus_stop   (ev_stop),
    .dr_rd      (dr_rd),
    .dr_wr      (dr_wr),
    .txe        (flags.txe),
    .rxne       (flags.rxne)
  );

  i2c_stop_seq u_stop (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .nack       (ev_nack),
    .bus_start  (ev_start),
    .bus_stop   (ev_stop),
    .is_master  (mode_master),
    .sr_rd      (sr_rd),
    .cr_wr      (cr_wr),
    .stopf      (flags.stopf),
    .nack_block (nack_block)
  );

  assign flags.arb  = w0c_q[0];
  assign flags.berr = w0c_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mode_master <= 1'b0;
    else if (!en)              mode_master <= 1'b0;
    else if (ev_arb_lost)      mode_master <= 1'b0;
    else if (ev_become_master) mode_master <= 1'b1;
  end

  always_comb begin
    sr_rdata           = '0;
    sr_rdata[ARB_BIT]  = flags.arb;
    sr_rdata[BERR_BIT] = flags.berr;
    sr_rdata[TXE_BIT]  = flags.txe;
    sr_rdata[RXNE_BIT] = flags.rxne;
    sr_rdata[STOP_BIT] = flags.stopf;
  end
endmodule

// File: rtl/i2c_evt_flags_chk.sv
`timescale 1ns/1ps
module i2c_evt_flags_chk
  import i2c_flag_pkg::*;
#(
  parameter int unsigned SR_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            ev_addr_phase,
  input logic            ev_tx_empty,
  input logic            ev_rx_full,
  input logic            ev_nack,
  input logic            ev_btf,
  input logic            ev_pec_next,
  input logic            ev_arb_lost,
  input logic            ev_start,
  input logic            ev_stop,
  input logic            dr_rd,
  input logic            dr_wr,
  input logic            sr_wr,
  input logic            cr_wr,
  input logic [SR_W-1:0] wdata,
  input logic [SR_W-1:0] sr_rdata,
  input logic            mode_master
);
  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (sr_rdata == '0) && !mode_master);

  p_arb_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && ev_arb_lost |=> sr_rdata[ARB_BIT]);

  p_write_one_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && sr_wr && wdata[ARB_BIT] && !ev_arb_lost |=> $stable(sr_rdata[ARB_BIT]));

  p_txe_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_rdata[TXE_BIT]) |-> $past(ev_tx_empty && !ev_addr_phase && !ev_pec_next && !ev_nack));

  p_txe_btf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && sr_rdata[TXE_BIT] && dr_wr && ev_btf && !ev_start && !ev_stop |=> sr_rdata[TXE_BIT]);

  p_rxne_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_rdata[RXNE_BIT]) |-> $past(ev_rx_full && !ev_addr_phase && !ev_arb_lost));

  p_rxne_read_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    en && dr_rd && !ev_btf && !ev_rx_full |=> !sr_rdata[RXNE_BIT]);

  p_stop_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_rdata[STOP_BIT]) |-> $past(ev_stop && !mode_master && !ev_nack));

  p_stop_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_rdata[STOP_BIT]) |-> $past(cr_wr || !en));

  p_mode_arb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && ev_arb_lost |=> !mode_master);

  p_reserved_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr_rdata[RSVD_BIT] == 1'b0);
endmodule

bind i2c_evt_flags i2c_evt_flags_chk #(.SR_W(SR_W)) u_chk (.*);

// File: tb/i2c_evt_flags_test.sv
`timescale 1ns/1ps
module i2c_evt_flags_test;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en, ev_addr_phase, ev_tx_empty, ev_rx_full, ev_nack, ev_btf, ev_pec_next;
  logic ev_first_byte, ev_arb_lost, ev_bus_err, ev_start, ev_stop, ev_become_master;
  logic dr_rd, dr_wr, sr_rd, sr_wr, cr_wr;
  logic [W-1:0] wdata;
  logic [W-1:0] sr_rdata;
  logic mode_master;

  int vectors = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic m_arb, m_berr, m_txe, m_rxne, m_stop, m_arm, m_nack, m_mode;
  logic [31:0] lfsr = 32'h1234_5679;

  always #5 clk = ~clk;

  i2c_evt_flags #(.SR_W(W)) uut (.*);

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic idle();
    {ev_addr_phase, ev_tx_empty, ev_rx_full, ev_nack, ev_btf, ev_pec_next} = '0;
    {ev_first_byte, ev_arb_lost, ev_bus_err, ev_start, ev_stop, ev_become_master} = '0;
    {dr_rd, dr_wr, sr_rd, sr_wr, cr_wr} = '0;
    wdata = '0;
  endtask

  function automatic void model_step();
    logic blk, n_arb, n_berr, n_txe, n_rxne, n_stop, n_arm, n_nack, n_mode;
    if (!en) begin
      {m_arb, m_berr, m_txe, m_rxne, m_stop, m_arm, m_nack, m_mode} = '0;
      return;
    end
    blk = m_nack | ev_nack;
    n_arb = ev_arb_lost ? 1'b1 : (sr_wr && !wdata[9]) ? 1'b0 : m_arb;
    n_berr = ev_bus_err ? 1'b1 : (sr_wr && !wdata[8]) ? 1'b0 : m_berr;
    if (ev_tx_empty && !ev_addr_phase && !ev_pec_next && !blk) n_txe = 1'b1;
    else if (ev_start || ev_stop || (dr_wr && !ev_btf && !ev_first_byte)) n_txe = 1'b0;
    else n_txe = m_txe;
    if (ev_rx_full && !ev_addr_phase && !ev_arb_lost) n_rxne = 1'b1;
    else if (dr_wr || (dr_rd && !ev_btf)) n_rxne = 1'b0;
    else n_rxne = m_rxne;
    if (ev_stop && !m_mode && !blk) n_stop = 1'b1;
    else if (cr_wr && m_arm) n_stop = 1'b0;
    else n_stop = m_stop;
    n_arm = cr_wr ? 1'b0 : (sr_rd && m_stop) ? 1'b1 : m_arm;
    n_nack = ev_nack ? 1'b1 : ev_start ? 1'b0 : m_nack;
    n_mode = ev_arb_lost ? 1'b0 : ev_become_master ? 1'b1 : m_mode;
    {m_arb, m_berr, m_txe, m_rxne, m_stop, m_arm, m_nack, m_mode} =
      {n_arb, n_berr, n_txe, n_rxne, n_stop, n_arm, n_nack, n_mode};
  endfunction

  task automatic compare_all();
    chk("R2 arbitration flag", W'(sr_rdata[9]), W'(m_arb));
    chk("R2 bus-error flag", W'(sr_rdata[8]), W'(m_berr));
    chk("R4 transmit-empty", W'(sr_rdata[7]), W'(m_txe));
    chk("R6 receive-not-empty", W'(sr_rdata[6]), W'(m_rxne));
    chk("R9 stop-detected", W'(sr_rdata[4]), W'(m_stop));
    chk("R10 mode bit", W'(mode_master), W'(m_mode));
    chk("R11 unused bits", sr_rdata & ~W'(16'h03D0), '0);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    idle();
  endtask

  initial begin
    #1ms;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    idle();
    en = 1'b0;
    {m_arb, m_berr, m_txe, m_rxne, m_stop, m_arm, m_nack, m_mode} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset status", sr_rdata, '0);
    chk("R1 reset mode", W'(mode_master), '0);
    en = 1'b1;

    // R3: address phase suppresses, clean event sets
    ev_tx_empty = 1; ev_addr_phase = 1; tick();
    chk("R3 txe in address phase", W'(sr_rdata[7]), '0);
    ev_tx_empty = 1; tick();
    chk("R3 txe set", W'(sr_rdata[7]), 1);
    ev_tx_empty = 1; ev_pec_next = 1; dr_wr = 1; tick();
    chk("R3 txe blocked by checksum byte", W'(sr_rdata[7]), '0);
    ev_tx_empty = 1; tick();
    // R4: write clear guarded by btf and first byte
    dr_wr = 1; ev_btf = 1; tick();
    chk("R4 write with btf keeps", W'(sr_rdata[7]), 1);
    dr_wr = 1; ev_first_byte = 1; tick();
    chk("R4 first byte keeps", W'(sr_rdata[7]), 1);
    dr_wr = 1; tick();
    chk("R4 write clears", W'(sr_rdata[7]), '0);
    // R7: NACK memory blocks transmit-empty until a start
    ev_nack = 1; tick();
    ev_tx_empty = 1; tick();
    chk("R7 txe blocked after nack", W'(sr_rdata[7]), '0);
    ev_start = 1; tick();
    ev_tx_empty = 1; tick();
    chk("R7 txe after start", W'(sr_rdata[7]), 1);
    // R5 / R6
    ev_rx_full = 1; ev_arb_lost = 1; tick();
    chk("R5 rxne blocked by arbitration loss", W'(sr_rdata[6]), '0);
    chk("R2 arbitration set", W'(sr_rdata[9]), 1);
    ev_rx_full = 1; tick();
    chk("R5 rxne set", W'(sr_rdata[6]), 1);
    dr_rd = 1; ev_btf = 1; tick();
    chk("R6 read with btf keeps", W'(sr_rdata[6]), 1);
    dr_rd = 1; tick();
    chk("R6 read clears", W'(sr_rdata[6]), '0);
    // R2: write 1 keeps, write 0 clears, set beats clear
    sr_wr = 1; wdata = '1; tick();
    chk("R2 write one keeps", W'(sr_rdata[9]), 1);
    sr_wr = 1; wdata = '0; tick();
    chk("R2 write zero clears", W'(sr_rdata[9]), '0);
    sr_wr = 1; wdata = '0; ev_bus_err = 1; tick();
    chk("R2 set wins over clear", W'(sr_rdata[8]), 1);
    // R10 / R8 / R9
    ev_become_master = 1; tick();
    chk("R10 mode master", W'(mode_master), 1);
    ev_stop = 1; tick();
    chk("R8 no stop flag in master", W'(sr_rdata[4]), '0);
    ev_arb_lost = 1; ev_become_master = 1; tick();
    chk("R10 arbitration beats master", W'(mode_master), '0);
    ev_stop = 1; tick();
    chk("R8 stop flag as slave", W'(sr_rdata[4]), 1);
    cr_wr = 1; tick();
    chk("R9 unarmed write keeps", W'(sr_rdata[4]), 1);
    sr_rd = 1; tick();
    cr_wr = 1; tick();
    chk("R9 read then write clears", W'(sr_rdata[4]), '0);
    ev_stop = 1; tick();
    sr_rd = 1; tick();
    en = 1'b0; ev_rx_full = 1; ev_arb_lost = 1; tick();
    chk("R1 disable clears all", sr_rdata, '0);
    en = 1'b1; cr_wr = 1; tick();

    // pseudo-random sweep
    for (int n = 0; n < 4000; n++) begin
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      en = (lfsr[3:0] != 4'd0);
      ev_addr_phase = lfsr[4] & lfsr[5];
      ev_tx_empty = lfsr[6]; ev_rx_full = lfsr[7];
      ev_nack = lfsr[8] & lfsr[9] & lfsr[10];
      ev_btf = lfsr[11] & lfsr[12]; ev_pec_next = lfsr[13] & lfsr[14];
      ev_first_byte = lfsr[15] & lfsr[16];
      ev_arb_lost = lfsr[17] & lfsr[18] & lfsr[19];
      ev_bus_err = lfsr[20] & lfsr[21];
      ev_start = lfsr[22] & lfsr[23]; ev_stop = lfsr[24] & lfsr[25];
      ev_become_master = lfsr[26] & lfsr[27];
      dr_rd = lfsr[28]; dr_wr = lfsr[29] & lfsr[4];
      sr_rd = lfsr[30]; sr_wr = lfsr[31] & lfsr[5]; cr_wr = lfsr[1] & lfsr[2];
      wdata = {lfsr[15:0] ^ lfsr[31:16]};
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule